// File: doc/BRIEF.md
# Posted Write Drain Master with Bounded Retry

This block empties a buffer of posted write data onto a downstream system bus as burst writes. The posted data was accepted earlier from a PCI-style initiator, which has already been told the write is complete. A command gives a start address and a beat count. The block then requests the bus and waits for an address acknowledge. After that it pushes one buffered word per data acknowledge, and the address and the remaining beat count advance with each accepted beat.

The downstream slave may answer in three other ways. If it asks for rearbitration, the block re-requests at the same address. If it ends the burst early, the block re-requests at the first word that was not yet written. Both cases draw on one retry budget per command, fixed at compile time. When the budget runs out, or when the slave reports an error, the posted data cannot be delivered. The block then gives up and raises a one-clock interrupt, flushes the buffer, and tells the PCI side to disconnect if a transfer is still running there.

Top module: `posted_wr_drain`

## Requirements
- R1: After reset, `drain_busy`, `bus_req`, `buf_rd_en`, `buf_flush`, `irq_pulse` and `pci_disc_data` are all 0.
- R2: In idle, a `cmd_start` with a nonzero `cmd_beats` makes `bus_req` 1 on the next cycle, with `bus_addr` equal to `cmd_addr` and `bus_beats` equal to `cmd_beats`.
- R3: In the data phase, each `bus_data_ack` pops one buffer word through `buf_rd_en`. `bus_wdata` is the buffer head. `bus_addr` advances by DW/8 bytes and `bus_beats` falls by one. After the last beat the block is idle with no interrupt.
- R4: While requesting, `bus_rearb` without `bus_addr_ack` keeps `bus_req` high at the same address, as long as the per-command retry count is below MAX_RETRY.
- R5: `bus_bterm` in the data phase with beats still left leads to a new request. That request resumes at the first unwritten word, with the remaining count, and uses the same retry budget as R4.
- R6: A rearbitrate or burst-terminate that arrives when MAX_RETRY retries are already used gives `irq_pulse` high for exactly one clock, on the next cycle.
- R7: `bus_err` during the request or the data phase aborts the command. No further beat is popped, and `irq_pulse` is high on the next cycle.
- R8: Whenever `irq_pulse` is high, `buf_flush` is also high. `buf_flush` stays high until `buf_empty`, and the block returns to idle on the cycle after `buf_empty` is seen.
- R9: `pci_disc_data` pulses together with the `irq_pulse` caused by `bus_err` only when `pci_xfer_active` was 1 at the error. Otherwise it stays 0.
- R10: The retry count clears at each new command and at each completion. Two commands in a row may each use MAX_RETRY retries without failing.
- R11: With MAX_RETRY = 0, the first rearbitrate fails the command at once and raises `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a drain command (taken in idle) |
| cmd_addr | input | AW | Start byte address of the command |
| cmd_beats | input | BW | Number of words to drain |
| drain_busy | output | 1 | A command or flush is in progress |
| buf_rd_en | output | 1 | Pop one word from the write buffer |
| buf_rd_data | input | DW | Head word of the write buffer |
| buf_empty | input | 1 | Write buffer holds no data |
| buf_flush | output | 1 | Discard all buffered data |
| bus_req | output | 1 | Downstream burst write request |
| bus_addr | output | AW | Address of the next unwritten word |
| bus_beats | output | BW | Words still to write |
| bus_wdata | output | DW | Write data for the current beat |
| bus_addr_ack | input | 1 | Slave accepted the address phase |
| bus_rearb | input | 1 | Slave asks for rearbitration |
| bus_data_ack | input | 1 | Slave accepted a data beat |
| bus_bterm | input | 1 | Slave ends the burst early |
| bus_err | input | 1 | Slave error or address-phase timeout |
| pci_xfer_active | input | 1 | PCI-side transfer still running |
| pci_disc_data | output | 1 | Request a disconnect-with-data on the PCI side |
| irq_pulse | output | 1 | One-clock failure interrupt |

## Verification
The bench runs a clean four-beat burst. This shows that address, data and count stepping work without any retry. A run of rearbitrates up to the limit and then one more separates "retried" from "failed". Two commands in a row, each using the full budget, show that the count clears per command instead of adding up. A burst terminate in the middle of a burst checks that the resumed request points at the first unwritten word. Errors in the address phase and in the data phase, with and without an active PCI transfer, separate the disconnect indication from the plain interrupt. A second instance with a zero budget shows immediate failure.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_FLUSH
    } drain_st_e;

    typedef struct packed {
        drain_st_e st;
        logic      irq;
        logic      disc;
    } drain_ctl_t;

endpackage

// File: rtl/pwd_retry_ctr.sv
module pwd_retry_ctr #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic can_retry
);
    localparam int RW = $clog2(MAX_RETRY + 2);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign can_retry = (cnt_q < RW'(MAX_RETRY));

endmodule

// File: rtl/pwd_beat_track.sv
module pwd_beat_track #(
    parameter int AW   = 32,
    parameter int BW   = 8,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [BW-1:0] ld_beats,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic [BW-1:0] beats_left
);
    logic [AW-1:0] addr_d, addr_q;
    logic [BW-1:0] left_d, left_q;

    always_comb begin
        addr_d = addr_q;
        left_d = left_q;
        if (load) begin
            addr_d = ld_addr;
            left_d = ld_beats;
        end else if (advance) begin
            addr_d = addr_q + AW'(STEP);
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else begin
            addr_q <= addr_d;
            left_q <= left_d;
        end
    end

    assign addr       = addr_q;
    assign beats_left = left_q;

endmodule

// File: rtl/posted_wr_drain.sv
module posted_wr_drain
    import pwd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BW        = 8,
    parameter int MAX_RETRY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [AW-1:0] cmd_addr,
    input  logic [BW-1:0] cmd_beats,
    output logic          drain_busy,
    output logic          buf_rd_en,
    input  logic [DW-1:0] buf_rd_data,
    input  logic          buf_empty,
    output logic          buf_flush,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [BW-1:0] bus_beats,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_addr_ack,
    input  logic          bus_rearb,
    input  logic          bus_data_ack,
    input  logic          bus_bterm,
    input  logic          bus_err,
    input  logic          pci_xfer_active,
    output logic          pci_disc_data,
    output logic          irq_pulse
);
    localparam int BYTES_PER_BEAT = DW / 8;

    drain_ctl_t ctl_d, ctl_q;

    logic rc_clear, rc_bump, can_retry;
    logic trk_load, trk_adv;
    logic retry_ev, fail_ev;
    logic last_beat;

    pwd_retry_ctr #(
        .MAX_RETRY (MAX_RETRY)
    ) retry_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rc_clear),
        .bump      (rc_bump),
        .can_retry (can_retry)
    );

    pwd_beat_track #(
        .AW   (AW),
        .BW   (BW),
        .STEP (BYTES_PER_BEAT)
    ) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (trk_load),
        .ld_addr    (cmd_addr),
        .ld_beats   (cmd_beats),
        .advance    (trk_adv),
        .addr       (bus_addr),
        .beats_left (bus_beats)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.irq  = 1'b0;
        ctl_d.disc = 1'b0;
        rc_clear   = 1'b0;
        rc_bump    = 1'b0;
        trk_load   = 1'b0;
        trk_adv    = 1'b0;
        retry_ev   = 1'b0;
        fail_ev    = 1'b0;
        last_beat  = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_start && (cmd_beats != '0)) begin
                    trk_load = 1'b1;
                    rc_clear = 1'b1;
                    ctl_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_err) begin
                    fail_ev = 1'b1;
                end else if (bus_addr_ack) begin
                    ctl_d.st = ST_DATA;
                end else if (bus_rearb) begin
                    retry_ev = 1'b1;
                end
            end
            ST_DATA: begin
                if (bus_err) begin
                    fail_ev = 1'b1;
                end else begin
                    trk_adv   = bus_data_ack;
                    last_beat = bus_data_ack && (bus_beats == BW'(1));
                    if (last_beat) begin
                        rc_clear = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end else if (bus_bterm) begin
                        retry_ev = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (buf_empty) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (retry_ev) begin
            if (can_retry) begin
                rc_bump  = 1'b1;
                ctl_d.st = ST_REQ;
            end else begin
                fail_ev = 1'b1;
            end
        end

        if (fail_ev) begin
            ctl_d.st   = ST_FLUSH;
            ctl_d.irq  = 1'b1;
            ctl_d.disc = bus_err && pci_xfer_active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, irq: 1'b0, disc: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drain_busy    = (ctl_q.st != ST_IDLE);
    assign bus_req       = (ctl_q.st == ST_REQ);
    assign buf_flush     = (ctl_q.st == ST_FLUSH);
    assign buf_rd_en     = (ctl_q.st == ST_DATA) && bus_data_ack && !bus_err;
    assign bus_wdata     = buf_rd_data;
    assign irq_pulse     = ctl_q.irq;
    assign pci_disc_data = ctl_q.disc;

endmodule

// File: rtl/pwd_drain_chk.sv
module pwd_drain_chk #(
    parameter int AW = 32,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_start,
    input logic [AW-1:0] cmd_addr,
    input logic [BW-1:0] cmd_beats,
    input logic          drain_busy,
    input logic          buf_rd_en,
    input logic          buf_empty,
    input logic          buf_flush,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic [BW-1:0] bus_beats,
    input logic          bus_addr_ack,
    input logic          bus_rearb,
    input logic          bus_err,
    input logic          pci_disc_data,
    input logic          irq_pulse
);
    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_busy && cmd_start && (cmd_beats != '0))
        |=> (bus_req && (bus_addr == $past(cmd_addr))));

    // R3
    last_beat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en && (bus_beats == BW'(1))) |=> (!drain_busy && !irq_pulse));

    // R4
    rearb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rearb && !bus_addr_ack && !bus_err)
        |=> ((bus_req && $stable(bus_addr)) || irq_pulse));

    // R6
    irq_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7
    err_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_req || (drain_busy && !buf_flush)) && bus_err) |=> (irq_pulse && !buf_rd_en));

    // R8
    irq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> buf_flush);

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_flush && buf_empty) |=> !drain_busy);

    // R9
    disc_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_disc_data |-> irq_pulse);

endmodule

bind posted_wr_drain pwd_drain_chk #(.AW(AW), .BW(BW)) chk_i (.*);

// File: tb/posted_wr_drain_tb_top.sv
`timescale 1ns/1ps
module posted_wr_drain_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 8;
    localparam int MAXR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] cmd_beats = '0;
    logic          drain_busy, buf_rd_en, buf_flush, bus_req, pci_disc_data, irq_pulse;
    logic [DW-1:0] buf_rd_data, bus_wdata;
    logic          buf_empty;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_beats;
    logic bus_addr_ack = 0, bus_rearb = 0, bus_data_ack = 0, bus_bterm = 0, bus_err = 0;
    logic pci_xfer_active = 0;

    // write buffer model
    logic [DW-1:0] fifo_mem [0:15];
    logic [3:0]    wr_p = '0;
    logic [3:0]    rd_p = '0;
    assign buf_empty   = (rd_p == wr_p);
    assign buf_rd_data = fifo_mem[rd_p];
    always @(posedge clk) begin
        if (buf_flush) rd_p <= wr_p;
        else if (buf_rd_en) rd_p <= rd_p + 4'd1;
    end

    int irq_cnt = 0;
    int disc_cnt = 0;
    always @(posedge clk) begin
        if (irq_pulse) irq_cnt <= irq_cnt + 1;
        if (pci_disc_data) disc_cnt <= disc_cnt + 1;
    end

    posted_wr_drain #(.AW(AW), .DW(DW), .BW(BW), .MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .drain_busy(drain_busy), .buf_rd_en(buf_rd_en),
        .buf_rd_data(buf_rd_data), .buf_empty(buf_empty), .buf_flush(buf_flush),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_beats(bus_beats),
        .bus_wdata(bus_wdata), .bus_addr_ack(bus_addr_ack), .bus_rearb(bus_rearb),
        .bus_data_ack(bus_data_ack), .bus_bterm(bus_bterm), .bus_err(bus_err),
        .pci_xfer_active(pci_xfer_active), .pci_disc_data(pci_disc_data),
        .irq_pulse(irq_pulse)
    );

    // zero-budget instance
    logic          z_start = 1'b0, z_rearb = 1'b0;
    logic          z_busy, z_rd_en, z_flush, z_req, z_disc, z_irq;
    logic [AW-1:0] z_addr;
    logic [BW-1:0] z_beats;
    logic [DW-1:0] z_wdata;

    posted_wr_drain #(.AW(AW), .DW(DW), .BW(BW), .MAX_RETRY(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .cmd_start(z_start), .cmd_addr(32'h40),
        .cmd_beats(8'd2), .drain_busy(z_busy), .buf_rd_en(z_rd_en),
        .buf_rd_data('0), .buf_empty(1'b1), .buf_flush(z_flush),
        .bus_req(z_req), .bus_addr(z_addr), .bus_beats(z_beats),
        .bus_wdata(z_wdata), .bus_addr_ack(1'b0), .bus_rearb(z_rearb),
        .bus_data_ack(1'b0), .bus_bterm(1'b0), .bus_err(1'b0),
        .pci_xfer_active(1'b0), .pci_disc_data(z_disc), .irq_pulse(z_irq)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input int n, input logic [DW-1:0] tag);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            fifo_mem[wr_p] = tag + DW'(k);
            wr_p = wr_p + 4'd1;
        end
        cmd_start = 1'b1; cmd_addr = a; cmd_beats = BW'(n);
        @(negedge clk);
        cmd_start = 1'b0;
        chk(bus_req, "R2 req", {31'd0, bus_req}, 1);
        chk(bus_addr == a, "R2 addr", bus_addr, a);
        chk(bus_beats == BW'(n), "R2 beats", {24'd0, bus_beats}, n);
    endtask

    task automatic addr_phase();
        bus_addr_ack = 1'b1;
        @(negedge clk);
        bus_addr_ack = 1'b0;
    endtask

    task automatic beat(input logic [AW-1:0] ea, input logic [DW-1:0] ed, input bit term);
        chk(bus_addr == ea, "R3 beat addr", bus_addr, ea);
        chk(bus_wdata == ed, "R3 beat data", bus_wdata, ed);
        bus_data_ack = 1'b1; bus_bterm = term;
        @(negedge clk);
        bus_data_ack = 1'b0; bus_bterm = 1'b0;
    endtask

    task automatic rearb_ok(input logic [AW-1:0] a);
        bus_rearb = 1'b1;
        @(negedge clk);
        bus_rearb = 1'b0;
        chk(bus_req && bus_addr == a && !irq_pulse, "R4 rearb retried", bus_addr, a);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10 && drain_busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!drain_busy && !bus_req && !buf_rd_en && !buf_flush && !irq_pulse && !pci_disc_data,
            "R1 reset", {26'd0, drain_busy, bus_req, buf_rd_en, buf_flush, irq_pulse, pci_disc_data}, 0);
    endtask

    task automatic t_clean();
        int i0 = irq_cnt;
        issue(32'h100, 4, 32'hA000);
        addr_phase();
        for (int k = 0; k < 4; k++) beat(32'h100 + 4*k, 32'hA000 + k, 0);
        chk(!drain_busy && buf_empty && irq_cnt == i0, "R3 complete", {31'd0, drain_busy}, 0);
    endtask

    task automatic t_rearb_then_ok(input logic [DW-1:0] tag);
        int i0 = irq_cnt;
        issue(32'h300, 2, tag);
        for (int r = 0; r < MAXR; r++) rearb_ok(32'h300);
        addr_phase();
        beat(32'h300, tag, 0);
        beat(32'h304, tag + 1, 0);
        chk(!drain_busy && irq_cnt == i0, "R10 full budget ok", irq_cnt - i0, 0);
    endtask

    task automatic t_exhaust();
        int i0 = irq_cnt;
        issue(32'h500, 3, 32'hC000);
        for (int r = 0; r < MAXR; r++) rearb_ok(32'h500);
        bus_rearb = 1'b1;
        @(negedge clk);
        bus_rearb = 1'b0;
        chk(irq_pulse, "R6 irq after exhaust", {31'd0, irq_pulse}, 1);
        chk(buf_flush, "R8 flush with irq", {31'd0, buf_flush}, 1);
        wait_idle();
        chk(!drain_busy && buf_empty, "R8 flushed idle", {31'd0, buf_empty}, 1);
        chk(irq_cnt - i0 == 1, "R6 single pulse", irq_cnt - i0, 1);
    endtask

    task automatic t_bterm();
        issue(32'h200, 5, 32'hB000);
        addr_phase();
        beat(32'h200, 32'hB000, 0);
        beat(32'h204, 32'hB001, 1);
        chk(bus_req && bus_addr == 32'h208, "R5 resume addr", bus_addr, 32'h208);
        chk(bus_beats == 3, "R5 resume beats", {24'd0, bus_beats}, 3);
        addr_phase();
        for (int k = 2; k < 5; k++) beat(32'h200 + 4*k, 32'hB000 + k, 0);
        chk(!drain_busy && buf_empty, "R5 completes", {31'd0, drain_busy}, 0);
    endtask

    task automatic t_err_data();
        int i0 = irq_cnt;
        int d0 = disc_cnt;
        pci_xfer_active = 1'b1;
        issue(32'h600, 4, 32'hD000);
        addr_phase();
        beat(32'h600, 32'hD000, 0);
        bus_err = 1'b1; bus_data_ack = 1'b1;
        @(negedge clk);
        bus_err = 1'b0; bus_data_ack = 1'b0; pci_xfer_active = 1'b0;
        chk(irq_pulse, "R7 irq on data err", {31'd0, irq_pulse}, 1);
        chk(pci_disc_data, "R9 disconnect", {31'd0, pci_disc_data}, 1);
        chk(bus_addr == 32'h604, "R7 no pop on err", bus_addr, 32'h604);
        wait_idle();
        chk(!drain_busy && buf_empty && irq_cnt - i0 == 1 && disc_cnt - d0 == 1,
            "R8 err flush", irq_cnt - i0, 1);
    endtask

    task automatic t_err_addr();
        int d0 = disc_cnt;
        issue(32'h700, 2, 32'hE000);
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
        chk(irq_pulse, "R7 irq on addr err", {31'd0, irq_pulse}, 1);
        chk(!pci_disc_data, "R9 no disconnect", {31'd0, pci_disc_data}, 0);
        wait_idle();
        chk(!drain_busy && buf_empty && disc_cnt == d0, "R9 idle no disc", disc_cnt - d0, 0);
    endtask

    task automatic t_zero_budget();
        @(negedge clk);
        z_start = 1'b1;
        @(negedge clk);
        z_start = 1'b0;
        chk(z_req && !z_irq, "R11 req", {31'd0, z_req}, 1);
        z_rearb = 1'b1;
        @(negedge clk);
        z_rearb = 1'b0;
        chk(z_irq && !z_req, "R11 immediate fail", {31'd0, z_irq}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean();
        t_rearb_then_ok(32'h1000);
        t_rearb_then_ok(32'h2000);
        t_exhaust();
        t_bterm();
        t_err_data();
        t_err_addr();
        t_zero_budget();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule